// File: doc/BRIEF.md
# Line Prefetch Execution Unit

This block carries out one cache-line prefetch micro-operation at a time. An operation arrives with a decoded form, a 64-bit base value and its deferred-exception (NaT) bit, an increment value with its own NaT bit, and a 9-bit immediate. It also carries a locality hint, an exclusive flag and a fault-mode flag. The block looks up the page attribute of the base line through a request/response port. If that line may be cached, it sends a line-aligned demand request on a valid/ready channel. In the update forms it then produces the post-incremented base for register writeback.

When the written-back base is not poisoned, the update forms also send a second, speculative request for the line at the incremented address. This request follows the demand request, never raises a fault, and is dropped if the channel does not take it in its single cycle. A poisoned base suppresses every memory reference, but the writeback still happens. Translation, the caches and fault delivery live elsewhere. The fault output is only a one-cycle indication.

Top module: `line_prefetch_unit`

## Requirements
- R1: After reset, `op_ready` is 1, and `pf_valid`, `wb_valid`, `fault_valid` and `attr_req_valid` are all 0.
- R2: Every lookup and request address has its low log2(LINE_BYTES) bits cleared. LINE_BYTES must be a power of two and at least 32.
- R3: The form is encoded in `op_form` as 0 = no update, 1 = register post-increment, 2 = immediate post-increment; code 3 acts as no update. Form 0 gives no writeback. Form 2 writes back base plus the sign-extended immediate. Form 1 writes back base plus `inc_val`.
- R4: The written-back NaT bit is `base_nat` OR (form 1 AND `inc_nat`). An increment NaT never raises a fault.
- R5: With `base_nat` set, no attribute lookup and no request are made. Forms 1 and 2 still write back.
- R6: In forms 1 and 2 with a clear written-back NaT, a second lookup and request are made for the line of the incremented base, after the demand request. This request has `pf_implicit`=1 and the same hint and exclusive flag. Form 0 never makes one.
- R7: The incremented-address request is shown for exactly one cycle. If `pf_ready` is low in that cycle it is dropped, and the writeback still follows.
- R8: A lookup answered with `attr_rsp_cacheable`=0 produces no request for that line.
- R9: A demand lookup answered with `attr_rsp_fault`=1 produces no demand request. In fault mode it pulses `fault_valid` once and ends the operation with no further lookup and no writeback. In no-fault mode the operation carries on silently. A fault reply to the incremented-address lookup only suppresses that request.
- R10: The demand request has `pf_implicit`=0, carries `op_hint` and `op_excl`, and stays valid with a stable address until `pf_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_form | input | 2 | Form code (0 none, 1 register, 2 immediate) |
| op_excl | input | 1 | Request exclusive ownership |
| op_fault_mode | input | 1 | Demand lookup may raise faults |
| op_hint | input | HINT_W | Locality hint |
| base_val | input | ADDR_W | Base address value |
| base_nat | input | 1 | Base deferred-exception bit |
| inc_val | input | ADDR_W | Increment register value |
| inc_nat | input | 1 | Increment deferred-exception bit |
| imm_val | input | IMM_W | Signed immediate increment |
| attr_req_valid | output | 1 | Attribute lookup pending |
| attr_req_addr | output | ADDR_W | Line address being looked up |
| attr_rsp_valid | input | 1 | Lookup answered |
| attr_rsp_cacheable | input | 1 | Page may be cached |
| attr_rsp_fault | input | 1 | Lookup would fault |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request taken |
| pf_addr | output | ADDR_W | Line-aligned request address |
| pf_hint | output | HINT_W | Locality hint of the request |
| pf_excl | output | 1 | Exclusive-state request |
| pf_implicit | output | 1 | 1 = incremented-address request, 0 = demand |
| wb_valid | output | 1 | Base writeback valid |
| wb_data | output | ADDR_W | Post-incremented base |
| wb_nat | output | 1 | NaT bit of the written-back base |
| fault_valid | output | 1 | Demand fault indication |

## Verification
The bench builds the unit with LINE_BYTES = 32, the smallest legal line. Alignment then clears exactly five bits, and the bench picks base values whose low bits are non-zero and increments that move to a different line. ADDR_W stays at 64, so attribute outcomes can be keyed on high address bits 40 (uncacheable) and 41 (faulting). This lets single operations reach every mix of demand and incremented-address outcomes. The responder stalls every demand request for two cycles, and one operation holds `pf_ready` low for the one-cycle incremented request.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_REG  = 2'd1,
    FORM_IMM  = 2'd2
  } lpf_form_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK_DEM,
    S_ISSUE_DEM,
    S_LOOK_IMP,
    S_ISSUE_IMP,
    S_WRITEBACK
  } lpf_state_e;

endpackage

// File: rtl/lpf_addr_gen.sv
module lpf_addr_gen
  import lpf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int IMM_W      = 9,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        form,
  input  logic [ADDR_W-1:0] base,
  input  logic              base_nat,
  input  logic [ADDR_W-1:0] inc,
  input  logic              inc_nat,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] dem_addr,
  output logic [ADDR_W-1:0] imp_addr,
  output logic [ADDR_W-1:0] upd_base,
  output logic              upd_nat
);

  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W)'(LINE_BYTES) - 1'b1);

  initial assert (LINE_BYTES >= 32 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
    else $error("LINE_BYTES must be a power of two of at least 32");

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;
  logic              sum_nat;

  always_comb begin
    step    = '0;
    sum_nat = base_nat;
    case (lpf_form_e'(form))
      FORM_IMM: step = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
      FORM_REG: begin
        step    = inc;
        sum_nat = base_nat | inc_nat;
      end
      default:  step = '0;
    endcase
    sum = base + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dem_addr <= '0;
      imp_addr <= '0;
      upd_base <= '0;
      upd_nat  <= 1'b0;
    end else if (load) begin
      dem_addr <= base & LINE_MASK;
      imp_addr <= sum & LINE_MASK;
      upd_base <= sum;
      upd_nat  <= sum_nat;
    end
  end

  // Both aligned copies keep the line offset clear after any load.
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (dem_addr[OFS_W-1:0] == '0) && (imp_addr[OFS_W-1:0] == '0)); // R2

endmodule

// File: rtl/lpf_seq.sv
module lpf_seq
  import lpf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int HINT_W     = 2,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_form,
  input  logic              op_excl,
  input  logic              op_fault_mode,
  input  logic [HINT_W-1:0] op_hint,
  input  logic              base_nat,
  output logic              load,
  input  logic [ADDR_W-1:0] dem_addr,
  input  logic [ADDR_W-1:0] imp_addr,
  input  logic              upd_nat,
  output logic              attr_req_valid,
  output logic [ADDR_W-1:0] attr_req_addr,
  input  logic              attr_rsp_valid,
  input  logic              attr_rsp_cacheable,
  input  logic              attr_rsp_fault,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [HINT_W-1:0] pf_hint,
  output logic              pf_excl,
  output logic              pf_implicit,
  output logic              wb_valid,
  output logic              fault_valid
);

  localparam int OFS_W = $clog2(LINE_BYTES);

  lpf_state_e        state_q, state_d;
  logic              excl_q, fm_q, upd_q, fault_q;
  logic [HINT_W-1:0] hint_q;
  lpf_state_e        after_dem;
  logic              fault_set;
  logic              op_upd;

  assign op_upd = (lpf_form_e'(op_form) == FORM_REG) || (lpf_form_e'(op_form) == FORM_IMM);
  assign load   = op_valid && (state_q == S_IDLE);

  always_comb begin
    if (!upd_q)      after_dem = S_IDLE;
    else if (upd_nat) after_dem = S_WRITEBACK;
    else             after_dem = S_LOOK_IMP;
  end

  always_comb begin
    state_d   = state_q;
    fault_set = 1'b0;
    case (state_q)
      S_IDLE: if (op_valid) begin
        if (base_nat) state_d = op_upd ? S_WRITEBACK : S_IDLE;
        else          state_d = S_LOOK_DEM;
      end
      S_LOOK_DEM: if (attr_rsp_valid) begin
        if (attr_rsp_fault) begin
          if (fm_q) begin
            fault_set = 1'b1;
            state_d   = S_IDLE;
          end else begin
            state_d = after_dem;
          end
        end else if (attr_rsp_cacheable) begin
          state_d = S_ISSUE_DEM;
        end else begin
          state_d = after_dem;
        end
      end
      S_ISSUE_DEM: if (pf_ready) state_d = after_dem;
      S_LOOK_IMP: if (attr_rsp_valid) begin
        state_d = (attr_rsp_cacheable && !attr_rsp_fault) ? S_ISSUE_IMP : S_WRITEBACK;
      end
      S_ISSUE_IMP: state_d = S_WRITEBACK;
      S_WRITEBACK: state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      excl_q  <= 1'b0;
      fm_q    <= 1'b0;
      upd_q   <= 1'b0;
      hint_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_set;
      if (load) begin
        excl_q <= op_excl;
        fm_q   <= op_fault_mode;
        upd_q  <= op_upd;
        hint_q <= op_hint;
      end
    end
  end

  assign op_ready       = (state_q == S_IDLE);
  assign attr_req_valid = (state_q == S_LOOK_DEM) || (state_q == S_LOOK_IMP);
  assign attr_req_addr  = (state_q == S_LOOK_IMP) ? imp_addr : dem_addr;
  assign pf_valid       = (state_q == S_ISSUE_DEM) || (state_q == S_ISSUE_IMP);
  assign pf_implicit    = (state_q == S_ISSUE_IMP);
  assign pf_addr        = pf_implicit ? imp_addr : dem_addr;
  assign pf_hint        = hint_q;
  assign pf_excl        = excl_q;
  assign wb_valid       = (state_q == S_WRITEBACK);
  assign fault_valid    = fault_q;

  AST_DEMAND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_implicit && !pf_ready) |=> (pf_valid && !pf_implicit && $stable(pf_addr))); // R10

  AST_IMPLICIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_implicit) |=> (!pf_valid && wb_valid)); // R7

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (pf_valid || attr_req_valid) |-> (pf_addr[OFS_W-1:0] == '0 && attr_req_addr[OFS_W-1:0] == '0)); // R2

  AST_FAULT_ENDS_OP: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (op_ready && !wb_valid && !pf_valid)); // R9

  AST_WB_ONLY_UPDATE: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> upd_q); // R3

  AST_NAT_NO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && base_nat) |=> !attr_req_valid); // R5

endmodule

// File: rtl/line_prefetch_unit.sv
module line_prefetch_unit
  import lpf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int IMM_W      = 9,
  parameter int HINT_W     = 2,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_form,
  input  logic              op_excl,
  input  logic              op_fault_mode,
  input  logic [HINT_W-1:0] op_hint,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_nat,
  input  logic [ADDR_W-1:0] inc_val,
  input  logic              inc_nat,
  input  logic [IMM_W-1:0]  imm_val,
  output logic              attr_req_valid,
  output logic [ADDR_W-1:0] attr_req_addr,
  input  logic              attr_rsp_valid,
  input  logic              attr_rsp_cacheable,
  input  logic              attr_rsp_fault,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [HINT_W-1:0] pf_hint,
  output logic              pf_excl,
  output logic              pf_implicit,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_data,
  output logic              wb_nat,
  output logic              fault_valid
);

  logic              load;
  logic [ADDR_W-1:0] dem_addr;
  logic [ADDR_W-1:0] imp_addr;
  logic              upd_nat;

  lpf_addr_gen #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .LINE_BYTES (LINE_BYTES)
  ) addr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .form     (op_form),
    .base     (base_val),
    .base_nat (base_nat),
    .inc      (inc_val),
    .inc_nat  (inc_nat),
    .imm      (imm_val),
    .dem_addr (dem_addr),
    .imp_addr (imp_addr),
    .upd_base (wb_data),
    .upd_nat  (upd_nat)
  );

  lpf_seq #(
    .ADDR_W     (ADDR_W),
    .HINT_W     (HINT_W),
    .LINE_BYTES (LINE_BYTES)
  ) seq_i (
    .clk                (clk),
    .rst                (rst),
    .op_valid           (op_valid),
    .op_ready           (op_ready),
    .op_form            (op_form),
    .op_excl            (op_excl),
    .op_fault_mode      (op_fault_mode),
    .op_hint            (op_hint),
    .base_nat           (base_nat),
    .load               (load),
    .dem_addr           (dem_addr),
    .imp_addr           (imp_addr),
    .upd_nat            (upd_nat),
    .attr_req_valid     (attr_req_valid),
    .attr_req_addr      (attr_req_addr),
    .attr_rsp_valid     (attr_rsp_valid),
    .attr_rsp_cacheable (attr_rsp_cacheable),
    .attr_rsp_fault     (attr_rsp_fault),
    .pf_valid           (pf_valid),
    .pf_ready           (pf_ready),
    .pf_addr            (pf_addr),
    .pf_hint            (pf_hint),
    .pf_excl            (pf_excl),
    .pf_implicit        (pf_implicit),
    .wb_valid           (wb_valid),
    .fault_valid        (fault_valid)
  );

  assign wb_nat = upd_nat;

  // A poisoned written-back base never leads to an incremented-address request.
  AST_NO_IMPLICIT_ON_NAT: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_implicit) |-> !wb_nat); // R6

endmodule

// File: tb/line_prefetch_unit_tb_top.sv
module line_prefetch_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LB         = 32;
  localparam int AW         = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [1:0]    op_form = '0;
  logic          op_excl = 1'b0;
  logic          op_fault_mode = 1'b0;
  logic [1:0]    op_hint = '0;
  logic [AW-1:0] base_val = '0;
  logic          base_nat = 1'b0;
  logic [AW-1:0] inc_val = '0;
  logic          inc_nat = 1'b0;
  logic [8:0]    imm_val = '0;
  logic          attr_req_valid;
  logic [AW-1:0] attr_req_addr;
  logic          attr_rsp_valid = 1'b0;
  logic          attr_rsp_cacheable = 1'b0;
  logic          attr_rsp_fault = 1'b0;
  logic          pf_valid;
  logic          pf_ready = 1'b0;
  logic [AW-1:0] pf_addr;
  logic [1:0]    pf_hint;
  logic          pf_excl;
  logic          pf_implicit;
  logic          wb_valid;
  logic [AW-1:0] wb_data;
  logic          wb_nat;
  logic          fault_valid;

  line_prefetch_unit #(.ADDR_W(AW), .IMM_W(9), .HINT_W(2), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_form(op_form),
    .op_excl(op_excl), .op_fault_mode(op_fault_mode), .op_hint(op_hint),
    .base_val(base_val), .base_nat(base_nat), .inc_val(inc_val), .inc_nat(inc_nat),
    .imm_val(imm_val), .attr_req_valid(attr_req_valid), .attr_req_addr(attr_req_addr),
    .attr_rsp_valid(attr_rsp_valid), .attr_rsp_cacheable(attr_rsp_cacheable),
    .attr_rsp_fault(attr_rsp_fault), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .pf_hint(pf_hint), .pf_excl(pf_excl), .pf_implicit(pf_implicit),
    .wb_valid(wb_valid), .wb_data(wb_data), .wb_nat(wb_nat), .fault_valid(fault_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int lookups = 0;
  int faults = 0;
  int stall = 0;
  bit imp_rdy = 1'b1;
  bit done = 1'b0;

  logic [67:0] exp_req_q[$];
  string       exp_req_tag[$];
  logic [64:0] exp_wb_q[$];
  string       exp_wb_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Attribute responder and request-channel ready, driven just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        attr_rsp_valid = 1'b0;
        pf_ready       = 1'b0;
        stall          = 0;
      end else begin
        attr_rsp_valid     = attr_req_valid && !attr_rsp_valid;
        attr_rsp_cacheable = !attr_req_addr[40];
        attr_rsp_fault     = attr_req_addr[41];
        if (pf_valid && pf_implicit) begin
          pf_ready = imp_rdy;
        end else if (pf_valid) begin
          pf_ready = (stall >= 2);
          stall++;
        end else begin
          pf_ready = 1'b0;
          stall    = 0;
        end
      end
    end
  end

  // Monitor: pops expected items as the design produces them.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (attr_req_valid && attr_rsp_valid) lookups++;
        if (fault_valid) faults++;
        if (pf_valid && pf_ready) begin
          if (exp_req_q.size() == 0) begin
            chk(1'b0, "R6 R8 R10", "unexpected request", {pf_implicit, pf_excl, pf_hint, pf_addr}, '0);
          end else begin
            logic [67:0] e;
            string t;
            e = exp_req_q.pop_front();
            t = exp_req_tag.pop_front();
            chk({pf_implicit, pf_excl, pf_hint, pf_addr} == e, t, "request",
                {pf_implicit, pf_excl, pf_hint, pf_addr}, e);
          end
        end
        if (wb_valid) begin
          if (exp_wb_q.size() == 0) begin
            chk(1'b0, "R3 R9", "unexpected writeback", {3'b0, wb_nat, wb_data}, '0);
          end else begin
            logic [64:0] e;
            string t;
            e = exp_wb_q.pop_front();
            t = exp_wb_tag.pop_front();
            chk({wb_nat, wb_data} == e, t, "writeback", {3'b0, wb_nat, wb_data}, {3'b0, e});
          end
        end
      end
    end
  end

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~(AW'(LB) - 1);
  endfunction

  // Driver: computes expectations from the requirements, then drives one operation.
  task automatic run_op(input logic [1:0] form, input bit excl, input bit fm,
                        input logic [1:0] hint, input logic [AW-1:0] base, input bit bnat,
                        input logic [AW-1:0] inc, input bit inat, input logic [8:0] imm,
                        input bit irdy, input string tag);
    logic [AW-1:0] step, newb, da, ia;
    bit wbnat, upd, stop;
    int lk, fexp;
    upd   = (form == 2'd1) || (form == 2'd2);
    step  = (form == 2'd2) ? {{55{imm[8]}}, imm} : (form == 2'd1) ? inc : '0;
    newb  = base + step;
    wbnat = bnat | ((form == 2'd1) & inat);
    da    = align(base);
    ia    = align(newb);
    lk    = 0;
    fexp  = 0;
    stop  = 1'b0;
    if (!bnat) begin
      lk = 1;
      if (da[41]) begin
        if (fm) begin
          fexp = 1;
          stop = 1'b1;
        end
      end else if (!da[40]) begin
        exp_req_q.push_back({1'b0, excl, hint, da});
        exp_req_tag.push_back(tag);
      end
    end
    if (!stop && upd && !wbnat) begin
      lk++;
      if (!ia[41] && !ia[40] && irdy) begin
        exp_req_q.push_back({1'b1, excl, hint, ia});
        exp_req_tag.push_back(tag);
      end
    end
    if (!stop && upd) begin
      exp_wb_q.push_back({wbnat, newb});
      exp_wb_tag.push_back(tag);
    end

    while (!op_ready) @(negedge clk);
    imp_rdy       = irdy;
    lookups       = 0;
    faults        = 0;
    op_form       = form;
    op_excl       = excl;
    op_fault_mode = fm;
    op_hint       = hint;
    base_val      = base;
    base_nat      = bnat;
    inc_val       = inc;
    inc_nat       = inat;
    imm_val       = imm;
    op_valid      = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    chk(lookups == lk, tag, "lookup count", 68'(lookups), 68'(lk));
    chk(faults == fexp, tag, "fault pulses", 68'(faults), 68'(fexp));
    imp_rdy = 1'b1;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R1", "watchdog expired", 68'(cyc), 68'd20000);
        finish_sim();
      end
    end
  end

  localparam logic [AW-1:0] B0   = 64'h0000_0012_3456_789F;
  localparam logic [AW-1:0] BIT40 = 64'h0000_0100_0000_0000;
  localparam logic [AW-1:0] BIT41 = 64'h0000_0200_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(op_ready == 1'b1, "R1", "op_ready", 68'(op_ready), 68'd1);
    chk(pf_valid == 1'b0, "R1", "pf_valid", 68'(pf_valid), 68'd0);
    chk(wb_valid == 1'b0, "R1", "wb_valid", 68'(wb_valid), 68'd0);
    chk(fault_valid == 1'b0, "R1", "fault_valid", 68'(fault_valid), 68'd0);
    chk(attr_req_valid == 1'b0, "R1", "attr_req_valid", 68'(attr_req_valid), 68'd0);

    run_op(2'd2, 1'b1, 1'b1, 2'd2, B0, 1'b0, '0, 1'b0, 9'd100, 1'b1, "R3 R6 R10");
    run_op(2'd2, 1'b0, 1'b0, 2'd0, 64'h0000_0000_1000_0005, 1'b0, '0, 1'b0, 9'h1F0, 1'b1, "R2 R3");
    run_op(2'd1, 1'b0, 1'b1, 2'd1, B0, 1'b0, 64'h40, 1'b0, '0, 1'b1, "R3 R6");
    run_op(2'd0, 1'b1, 1'b0, 2'd3, B0, 1'b0, 64'h1000, 1'b0, 9'd8, 1'b1, "R3 R6");
    run_op(2'd3, 1'b0, 1'b0, 2'd1, B0, 1'b0, 64'h1000, 1'b0, 9'd8, 1'b1, "R3");
    run_op(2'd1, 1'b0, 1'b1, 2'd2, B0, 1'b0, 64'h80, 1'b1, '0, 1'b1, "R4");
    run_op(2'd2, 1'b1, 1'b1, 2'd1, B0, 1'b1, '0, 1'b0, 9'd64, 1'b1, "R5");
    run_op(2'd0, 1'b0, 1'b1, 2'd1, B0, 1'b1, '0, 1'b0, 9'd64, 1'b1, "R5");
    run_op(2'd2, 1'b0, 1'b0, 2'd0, B0 | BIT40, 1'b0, '0, 1'b0, 9'd4, 1'b1, "R8");
    run_op(2'd1, 1'b1, 1'b0, 2'd3, B0, 1'b0, BIT40, 1'b0, '0, 1'b1, "R8 R6");
    run_op(2'd1, 1'b0, 1'b1, 2'd2, B0 | BIT41, 1'b0, -BIT41, 1'b0, '0, 1'b1, "R9");
    run_op(2'd1, 1'b0, 1'b0, 2'd2, B0 | BIT41, 1'b0, -BIT41, 1'b0, '0, 1'b1, "R9");
    run_op(2'd2, 1'b1, 1'b0, 2'd1, B0, 1'b0, '0, 1'b0, 9'd200, 1'b0, "R7");
    run_op(2'd1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_0000_003F, 1'b0, 64'h0000_0000_0001_0021, 1'b0, '0, 1'b1, "R2 R10");

    repeat (4) @(negedge clk);
    chk(exp_req_q.size() == 0, "R6 R10", "requests missing", 68'(exp_req_q.size()), 68'd0);
    chk(exp_wb_q.size() == 0, "R3 R5", "writebacks missing", 68'(exp_wb_q.size()), 68'd0);
    done = 1'b1;
    finish_sim();
  end

endmodule